// File: doc/BRIEF.md
# FIS Type Acceptance Filter

This block sits on the receive side of a Serial ATA host link. When a frame begins, it captures the header dword and takes the frame type code from bits [7:0]. The code selects one of fifteen 2-bit policy fields: fourteen of them belong to specific codes, and one is shared by every code that has no field of its own. When the frame ends, the block combines that policy with the error flag and a BIST sub-mode check. From these it decides whether the link layer answers the device with a receive-ok or a receive-error handshake, whether the host gets a notification pulse and whether an interlock flag is raised.

Software changes the policies through a small write port. A policy field is given one of three meanings: accept, reject, or accept with interlock. After an interlocked frame, the interlock flag stays set until software writes a clear command. The handshake decision appears for one cycle after the frame-end strobe. The link layer then turns it into the matching primitive.

Top module: `fis_type_filter`

## Requirements
- R1: The type code is header bits [7:0]. The codes 27h, 34h, 39h, 41h, 46h, 58h, 5Fh, A1h, A6h, B8h, BFh, C7h, D4h and D9h use policy slots 0 through 13 in that order. Every other code uses shared slot 14.
- R2: After reset, slots 1, 2, 4, 5, 6 and 7 (codes 34h, 39h, 46h, 58h, 5Fh and A1h) hold policy 00 (accept). All other slots, including shared slot 14, hold 01 (reject).
- R3: A frame whose policy is 01 gets R_ERR (hs_ok=0) whatever the error flag says, and it raises no host notification.
- R4: A frame that is accepted gets R_OK (hs_ok=1) when frm_err is 0 at the frame-end strobe. It gets R_ERR with no notification when frm_err is 1.
- R5: hs_valid is high for exactly the one cycle after each frm_end strobe. hs_ok and host_notify carry the decision for that frame in that cycle.
- R6: host_notify pulses only together with hs_valid. For an error-free accepted frame without interlock, it pulses only for codes 34h, 39h, 41h, 5Fh and A1h.
- R7: A code 58h frame is accepted only when header bit BIST_LPBK_BIT (default 18) is 1. When that bit is 0, the frame gets R_ERR with no notification.
- R8: A policy with bit 1 set means accept with interlock. An error-free frame under such a policy gets R_OK and a host notification, and it sets ilk_flag in the hs_valid cycle. ilk_flag then stays set until a write to address 15 with cfg_wdata bit 0 set.
- R9: When cfg_we is high and cfg_addr is 0 to 14, cfg_wdata is written into that slot. The policy held at the frame-end strobe governs the frame.
- R10: A frm_end with no frm_start since the previous frm_end gets R_ERR with no notification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frm_start | input | 1 | First-dword strobe, header valid |
| hdr_dword | input | 32 | First received dword |
| frm_end | input | 1 | Frame-end strobe |
| frm_err | input | 1 | Error detected in the frame, valid with frm_end |
| cfg_we | input | 1 | Policy write enable |
| cfg_addr | input | 4 | Slot 0-14, or 15 for interlock clear |
| cfg_wdata | input | 2 | Policy value, or bit 0 as the clear command |
| hs_valid | output | 1 | Handshake decision valid |
| hs_ok | output | 1 | 1 = R_OK, 0 = R_ERR |
| host_notify | output | 1 | Host notification pulse |
| ilk_flag | output | 1 | Interlock pending |

## Verification
Frames are sent with each of the 256 type codes under the reset policies. This separates the fourteen dedicated slots from the shared slot and shows which codes notify. The 58h frames are sent with the loopback bit set and with it clear, which isolates the BIST exception from the policy lookup. The error flag is set on both accepted and rejected frames, which shows that an error can only demote a decision. The bench then rewrites slots to reject, accept and interlock, and sends a frame-end without a start, to check the write path, the sticky interlock with its clear, and the missing-header case.

// File: rtl/fis_filt_pkg.sv
package fis_filt_pkg;
  localparam int NSLOT     = 15;
  localparam int SLOT_W    = 4;
  localparam int POL_W     = 2;
  localparam int OTHER_SLT = NSLOT - 1;
  localparam logic [SLOT_W-1:0] ILK_CLR_ADDR = 4'd15;

  typedef logic [POL_W-1:0] pol_t;

  localparam pol_t POL_ACCEPT = 2'b00;
  localparam pol_t POL_REJECT = 2'b01;

  localparam logic [7:0] CODE_BIST = 8'h58;

  function automatic logic [SLOT_W-1:0] slot_of(input logic [7:0] code);
    case (code)
      8'h27: return 4'd0;
      8'h34: return 4'd1;
      8'h39: return 4'd2;
      8'h41: return 4'd3;
      8'h46: return 4'd4;
      8'h58: return 4'd5;
      8'h5F: return 4'd6;
      8'hA1: return 4'd7;
      8'hA6: return 4'd8;
      8'hB8: return 4'd9;
      8'hBF: return 4'd10;
      8'hC7: return 4'd11;
      8'hD4: return 4'd12;
      8'hD9: return 4'd13;
      default: return 4'(OTHER_SLT);
    endcase
  endfunction

  function automatic pol_t default_pol(input int slot);
    case (slot)
      1, 2, 4, 5, 6, 7: return POL_ACCEPT;
      default:          return POL_REJECT;
    endcase
  endfunction

  function automatic logic notify_needed(input logic [7:0] code);
    return (code == 8'h34) || (code == 8'h39) || (code == 8'h41) ||
           (code == 8'h5F) || (code == 8'hA1);
  endfunction

  function automatic logic pol_is_reject(input pol_t p);
    return (p == POL_REJECT);
  endfunction

  function automatic logic pol_is_interlock(input pol_t p);
    return p[1];
  endfunction
endpackage

// File: rtl/fis_policy_bank.sv
module fis_policy_bank
  import fis_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  pol_t              wr_pol,
  input  logic [SLOT_W-1:0] rd_slot,
  output pol_t              rd_pol
);
  pol_t pol_q [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pol_q[i] <= default_pol(i);
      else if (wr_en && wr_slot == SLOT_W'(i))
        pol_q[i] <= wr_pol;
    end
  end

  always_comb begin
    rd_pol = pol_q[OTHER_SLT];
    for (int i = 0; i < NSLOT; i++)
      if (rd_slot == SLOT_W'(i)) rd_pol = pol_q[i];
  end

  // R9
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot == rd_slot && wr_slot < SLOT_W'(NSLOT)) |=>
      (rd_pol == $past(wr_pol) || $past(rd_slot) != rd_slot));
endmodule

// File: rtl/fis_hdr_capture.sv
module fis_hdr_capture (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_start,
  input  logic       frm_end,
  input  logic [7:0] hdr_code,
  input  logic       hdr_lpbk,
  output logic [7:0] cur_code,
  output logic       cur_lpbk,
  output logic       hdr_seen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_code <= '0;
      cur_lpbk <= 1'b0;
      hdr_seen <= 1'b0;
    end else if (frm_start) begin
      cur_code <= hdr_code;
      cur_lpbk <= hdr_lpbk;
      hdr_seen <= 1'b1;
    end else if (frm_end) begin
      hdr_seen <= 1'b0;
    end
  end

  // R10
  seen_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_end && !frm_start) |=> !hdr_seen);
endmodule

// File: rtl/fis_verdict.sv
module fis_verdict
  import fis_filt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_end,
  input  logic       frm_err,
  input  logic       hdr_seen,
  input  logic [7:0] cur_code,
  input  logic       cur_lpbk,
  input  pol_t       cur_pol,
  input  logic       ilk_clr,
  output logic       hs_valid,
  output logic       hs_ok,
  output logic       host_notify,
  output logic       ilk_flag
);
  logic is_bist, bist_refused, pol_reject, ilk_mode;
  logic accept_w, ok_w, notify_w, ilk_set;

  assign is_bist      = (cur_code == CODE_BIST);
  assign bist_refused = is_bist && !cur_lpbk;
  assign pol_reject   = pol_is_reject(cur_pol);
  assign ilk_mode     = pol_is_interlock(cur_pol);
  assign accept_w     = hdr_seen && !pol_reject && !bist_refused;
  assign ok_w         = accept_w && !frm_err;
  assign notify_w     = ok_w && (notify_needed(cur_code) || ilk_mode);
  assign ilk_set      = frm_end && ok_w && ilk_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_valid    <= 1'b0;
      hs_ok       <= 1'b0;
      host_notify <= 1'b0;
    end else begin
      hs_valid    <= frm_end;
      host_notify <= frm_end && notify_w;
      if (frm_end) hs_ok <= ok_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ilk_flag <= 1'b0;
    else if (ilk_set) ilk_flag <= 1'b1;
    else if (ilk_clr) ilk_flag <= 1'b0;
  end

  // R5
  hs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end |=> hs_valid);
  // R5
  hs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> $past(frm_end));
  // R3
  reject_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_end && pol_reject) |=> (!hs_ok && !host_notify));
  // R4
  notify_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_notify |-> (hs_ok && hs_valid));
  // R7
  bist_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_end && bist_refused) |=> !hs_ok);
  // R8
  ilk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ilk_flag && !ilk_clr) |=> ilk_flag);
  // R10
  no_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_end && !hdr_seen) |=> (!hs_ok && !host_notify));
endmodule

// File: rtl/fis_type_filter.sv
module fis_type_filter
  import fis_filt_pkg::*;
#(
  parameter int HDR_W         = 32,
  parameter int BIST_LPBK_BIT = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_start,
  input  logic [HDR_W-1:0] hdr_dword,
  input  logic             frm_end,
  input  logic             frm_err,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_addr,
  input  logic [1:0]       cfg_wdata,
  output logic             hs_valid,
  output logic             hs_ok,
  output logic             host_notify,
  output logic             ilk_flag
);
  logic [7:0]        cur_code;
  logic              cur_lpbk, hdr_seen;
  logic [SLOT_W-1:0] cur_slot;
  pol_t              cur_pol;
  logic              pol_wr, ilk_clr;

  assign pol_wr   = cfg_we && (cfg_addr < SLOT_W'(NSLOT));
  assign ilk_clr  = cfg_we && (cfg_addr == ILK_CLR_ADDR) && cfg_wdata[0];
  assign cur_slot = slot_of(cur_code);

  fis_hdr_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_start(frm_start),
    .frm_end  (frm_end),
    .hdr_code (hdr_dword[7:0]),
    .hdr_lpbk (hdr_dword[BIST_LPBK_BIT]),
    .cur_code (cur_code),
    .cur_lpbk (cur_lpbk),
    .hdr_seen (hdr_seen)
  );

  fis_policy_bank u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (pol_wr),
    .wr_slot(cfg_addr),
    .wr_pol (cfg_wdata),
    .rd_slot(cur_slot),
    .rd_pol (cur_pol)
  );

  fis_verdict u_verd (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_end    (frm_end),
    .frm_err    (frm_err),
    .hdr_seen   (hdr_seen),
    .cur_code   (cur_code),
    .cur_lpbk   (cur_lpbk),
    .cur_pol    (cur_pol),
    .ilk_clr    (ilk_clr),
    .hs_valid   (hs_valid),
    .hs_ok      (hs_ok),
    .host_notify(host_notify),
    .ilk_flag   (ilk_flag)
  );

  // R1
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_slot < SLOT_W'(NSLOT));
endmodule

// File: tb/fis_type_filter_tb.sv
module fis_type_filter_tb;
  localparam int LPBK = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_start = 1'b0, frm_end = 1'b0, frm_err = 1'b0;
  logic [31:0] hdr_dword = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [1:0] cfg_wdata = '0;
  logic hs_valid, hs_ok, host_notify, ilk_flag;

  int checks = 0, errors = 0;
  logic [1:0] mirror [15];
  bit exp_ilk = 1'b0;
  logic [2:0] exp_q [$];
  string tag_q [$];

  always #2 clk = ~clk;

  fis_type_filter u_dut (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .hdr_dword(hdr_dword),
    .frm_end(frm_end), .frm_err(frm_err), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hs_valid(hs_valid), .hs_ok(hs_ok),
    .host_notify(host_notify), .ilk_flag(ilk_flag)
  );

  function automatic int tb_slot(input logic [7:0] c);
    logic [7:0] known [14] = '{8'h27, 8'h34, 8'h39, 8'h41, 8'h46, 8'h58, 8'h5F,
                               8'hA1, 8'hA6, 8'hB8, 8'hBF, 8'hC7, 8'hD4, 8'hD9};
    for (int k = 0; k < 14; k++) if (known[k] == c) return k;
    return 14;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [7:0] c, input bit lp, input bit err,
                          input bit seen, input string tag);
    logic [1:0] p;
    bit acc, ok, nt, ik;
    p   = mirror[tb_slot(c)];
    acc = seen && (p != 2'b01) && !(c == 8'h58 && !lp);
    ok  = acc && !err;
    ik  = ok && p[1];
    nt  = ok && (p[1] || c == 8'h34 || c == 8'h39 || c == 8'h41 || c == 8'h5F || c == 8'hA1);
    if (ik) exp_ilk = 1'b1;
    exp_q.push_back({ok, nt, exp_ilk});
    tag_q.push_back(tag);
  endtask

  task automatic send_frame(input logic [7:0] c, input bit lp, input bit err, input string tag);
    push_exp(c, lp, err, 1'b1, tag);
    @(posedge clk); #1;
    hdr_dword = '0; hdr_dword[7:0] = c; hdr_dword[LPBK] = lp;
    frm_start = 1'b1;
    @(posedge clk); #1;
    frm_start = 1'b0; frm_end = 1'b1; frm_err = err;
    @(posedge clk); #1;
    frm_end = 1'b0; frm_err = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic end_only(input string tag);
    push_exp(8'h34, 1'b1, 1'b0, 1'b0, tag);
    @(posedge clk); #1;
    frm_end = 1'b1;
    @(posedge clk); #1;
    frm_end = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [1:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (a < 4'd15) mirror[a] = d;
    else if (d[0]) exp_ilk = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (host_notify && !hs_valid) check("R6", host_notify, 1'b0, "notify without hs_valid");
      if (hs_valid) begin
        if (exp_q.size() == 0) begin
          check("R5", hs_valid, 1'b0, "unexpected hs_valid");
        end else begin
          logic [2:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, hs_ok, e[2], "hs_ok");
          check(t, host_notify, e[1], "host_notify");
          check(t, ilk_flag, e[0], "ilk_flag");
        end
      end
    end
  end

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 15; s++)
      mirror[s] = (s == 1 || s == 2 || s == 4 || s == 5 || s == 6 || s == 7) ? 2'b00 : 2'b01;
    repeat (3) @(posedge clk);
    #1;
    check("R5", hs_valid, 1'b0, "reset hs_valid");
    check("R6", host_notify, 1'b0, "reset notify");
    check("R8", ilk_flag, 1'b0, "reset ilk");
    rst_n = 1'b1;

    // R1 R2 R6: every code against reset defaults
    for (int c = 0; c < 256; c++) send_frame(8'(c), 1'b1, 1'b0, "R2");
    // R7: BIST without loopback bit
    send_frame(8'h58, 1'b0, 1'b0, "R7");
    send_frame(8'h58, 1'b1, 1'b0, "R7");
    // R4: error flag on accepted frames
    send_frame(8'h34, 1'b1, 1'b1, "R4");
    send_frame(8'h46, 1'b1, 1'b1, "R4");
    // R3: error flag on rejected frame
    send_frame(8'h41, 1'b1, 1'b1, "R3");
    // R9 R3: reject a default-accepted code
    cfg_write(4'd1, 2'b01);
    send_frame(8'h34, 1'b1, 1'b0, "R9");
    // R9 R1: open the shared slot
    cfg_write(4'd14, 2'b00);
    send_frame(8'h00, 1'b1, 1'b0, "R1");
    send_frame(8'hFF, 1'b1, 1'b0, "R1");
    send_frame(8'hA6, 1'b1, 1'b0, "R1");
    // R9: accept DMA setup
    cfg_write(4'd3, 2'b00);
    send_frame(8'h41, 1'b1, 1'b0, "R9");
    // R8: interlock on data frame
    cfg_write(4'd4, 2'b10);
    send_frame(8'h46, 1'b1, 1'b1, "R8");
    send_frame(8'h46, 1'b1, 1'b0, "R8");
    send_frame(8'h39, 1'b1, 1'b0, "R8");
    cfg_write(4'd15, 2'b00);
    #1 check("R8", ilk_flag, 1'b1, "ilk after no-op clear");
    cfg_write(4'd15, 2'b01);
    #1 check("R8", ilk_flag, 1'b0, "ilk after clear");
    cfg_write(4'd2, 2'b11);
    send_frame(8'h39, 1'b1, 1'b0, "R8");
    cfg_write(4'd15, 2'b01);
    #1 check("R8", ilk_flag, 1'b0, "ilk after second clear");
    // R10: end without start
    end_only("R10");
    repeat (4) @(posedge clk);
    #1 check("R5", (exp_q.size() == 0), 1'b1, "all results seen");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule